// File: doc/BRIEF.md
# Serial Audio Deserializer

This block turns a three-wire serial audio stream into parallel samples. The three wires are a bit clock, a word select and serial data. The incoming lines pass through a synchronizer into the core clock domain. The block then picks out the selected bit-clock edge and counts bit positions from a word-select transition that marks the start of a frame. Each frame yields one left and one right sample of 16 bits.

For each channel, capture begins at a configurable bit position. The captured field runs down to a programmable stop bit, in either MSB-first or LSB-first order. The result always ends up left-justified, and every bit below the stop position reads as zero. Both samples are presented together with a one-cycle valid strobe once the right channel's field is complete.

An optional master mode derives the bit clock and word select from the core clock, which then serves as the oversampling clock. In that mode the block captures from its own generated clocks. All settings are static input ports that are meant to change only while reset is held.

Top module: `audio_ser_rx`

## Requirements
- R1: While reset is asserted and directly after it, left_out, right_out, valid_out and err_out are all zero.
- R2: cfg_frame_pol=0 starts a frame on a high-to-low word-select change and 1 on a low-to-high change. The data bit sampled together with the first word-select sample at the new level is frame position 0.
- R3: With cfg_lsb_first=0 (MSB-first), the bit at position cfg_left_start goes to left_out[15]. Each later bit fills the next lower index, down to and including index cfg_stop_pos.
- R4: With cfg_lsb_first=1 (LSB-first), the bit at position cfg_left_start goes to left_out[cfg_stop_pos]. Each later bit fills the next higher index, up to and including index 15.
- R5: Bits of left_out and right_out below index cfg_stop_pos are always zero when valid_out is high.
- R6: right_out follows the same rules from position cfg_right_start. valid_out pulses for exactly one cycle after the last bit of the right field. left_out and right_out change only in that cycle.
- R7: cfg_fall_edge=0 samples data and word select on rising bit-clock edges, and cfg_fall_edge=1 samples them on falling edges.
- R8: If a frame start arrives while either channel field is incomplete, err_out pulses for one cycle. The partial sample is dropped: no valid_out is produced for it, and the next complete frame's values are output.
- R9: The position counter saturates at 64 instead of wrapping. A frame longer than 64 bits yields exactly one sample.
- R10: With cfg_master=1, sck_out has a period of cfg_sck_div+1 core cycles and a frame of cfg_ws_div+1 bits. For cfg_frame_pol=0, ws_out is low for the first half of the frame and high for the second half.
- R11: With cfg_master=1, ws_out changes only together with a bit-clock change to the level cfg_fall_edge, which is the edge opposite the sampling edge.
- R12: With cfg_master=1, samples are captured from sd_in using the generated clocks. With a stop at 4 and starts at 0 and 32, frame bits 0..11 land in left_out[15:4] and bits 32..43 land in right_out[15:4].
- R13: With cfg_master=0, sck_out and ws_out stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; oversampling clock in master mode |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: generate bit clock and word select |
| cfg_sck_div | input | 8 | Bit-clock divider; period is value+1 core cycles |
| cfg_ws_div | input | 6 | Frame length minus one, in bits (master mode) |
| cfg_frame_pol | input | 1 | 0: frame starts on a falling word select; 1: on a rising one |
| cfg_fall_edge | input | 1 | 0: sample on rising bit-clock edges; 1: on falling edges |
| cfg_lsb_first | input | 1 | 0: MSB-first fill; 1: LSB-first fill |
| cfg_stop_pos | input | 4 | Lowest captured bit index; lower bits are zeroed |
| cfg_left_start | input | 6 | Frame position of the first left bit |
| cfg_right_start | input | 6 | Frame position of the first right bit |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word select |
| left_out | output | 16 | Left sample, left-justified |
| right_out | output | 16 | Right sample, left-justified |
| valid_out | output | 1 | One-cycle strobe; new samples present |
| err_out | output | 1 | One-cycle strobe; partial sample discarded |

## Verification
A wrong position count or a missed frame start shows up at the ports within one frame. The samples come out shifted by whole bits, valid_out goes missing or repeats, or err_out fires spuriously. A wrong fill order or stop handling shows up on the very next valid_out, as a mirrored field or nonzero low bits. A divider fault in master mode is visible within a single bit period on sck_out, and a faulty frame counter is visible within one frame on ws_out.

// File: rtl/audio_ser_rx_pkg.sv
`timescale 1ns/1ps
package audio_ser_rx_pkg;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;

    typedef enum logic {
        START_ON_FALL = 1'b0,
        START_ON_RISE = 1'b1
    } frame_pol_e;

endpackage

// File: rtl/audio_ser_rx_sync.sv
`timescale 1ns/1ps
module audio_ser_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/audio_ser_rx_clkgen.sv
`timescale 1ns/1ps
module audio_ser_rx_clkgen #(
    parameter int DIV_W = 8,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [POS_W-1:0] ws_div_i,
    input  logic             pol_i,
    input  logic             fall_edge_i,
    output logic             sck_o,
    output logic             ws_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [POS_W-1:0] wsc;
        logic             sck;
        logic             ws;
    } gen_st_t;

    gen_st_t          gen_q, gen_d;
    logic [DIV_W:0]   half_w;
    logic [POS_W:0]   ws_half_w;
    logic             hit_rise, hit_fall, drive;
    logic [POS_W-1:0] wsc_nx;

    always_comb begin
        half_w    = ({1'b0, div_i} + 1'b1) >> 1;
        ws_half_w = ({1'b0, ws_div_i} + 1'b1) >> 1;
        hit_rise  = en_i && ({1'b0, gen_q.cnt} == (half_w - 1'b1));
        hit_fall  = en_i && (gen_q.cnt == div_i);
        // word select moves on the edge opposite the sampling edge
        drive     = fall_edge_i ? hit_rise : hit_fall;
        wsc_nx    = (gen_q.wsc == ws_div_i) ? '0 : gen_q.wsc + 1'b1;

        gen_d = gen_q;
        if (!en_i) begin
            gen_d = '0;
        end else begin
            gen_d.cnt = hit_fall ? '0 : gen_q.cnt + 1'b1;
            if (hit_rise) gen_d.sck = 1'b1;
            if (hit_fall) gen_d.sck = 1'b0;
            if (drive) begin
                gen_d.wsc = wsc_nx;
                gen_d.ws  = ({1'b0, wsc_nx} >= ws_half_w) ^ pol_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck_o  = gen_q.sck;
    assign ws_o   = gen_q.ws;
    assign rise_o = hit_rise;
    assign fall_o = hit_fall;

endmodule

// File: rtl/audio_ser_rx_capture.sv
`timescale 1ns/1ps
module audio_ser_rx_capture
    import audio_ser_rx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int POS_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        evt_i,
    input  logic                        ws_i,
    input  logic                        sd_i,
    input  logic                        pol_i,
    input  logic                        lsb_i,
    input  logic [$clog2(SAMPLE_W)-1:0] stop_i,
    input  logic [POS_W-1:0]            lstart_i,
    input  logic [POS_W-1:0]            rstart_i,
    output logic [SAMPLE_W-1:0]         left_o,
    output logic [SAMPLE_W-1:0]         right_o,
    output logic                        valid_o,
    output logic                        err_o
);

    localparam int STOP_W  = $clog2(SAMPLE_W);
    localparam int CNT_W   = POS_W + 1;
    localparam int POS_SAT = 2 ** POS_W;

    typedef struct packed {
        logic                hit;
        logic                last;
        logic [SAMPLE_W-1:0] acc;
    } lane_t;

    typedef struct packed {
        logic                seen;
        logic                ws_prev;
        logic [CNT_W-1:0]    pos;
        logic [SAMPLE_W-1:0] lw;
        logic [SAMPLE_W-1:0] rw;
        logic                lbusy;
        logic                rbusy;
        logic [SAMPLE_W-1:0] lo;
        logic [SAMPLE_W-1:0] ro;
        logic                vld;
        logic                err;
    } cap_st_t;

    // place one serial bit into a channel accumulator if pos lies in its field
    function automatic lane_t lane_step(
        input logic [SAMPLE_W-1:0] acc,
        input logic                bit_v,
        input logic [CNT_W-1:0]    pos,
        input logic [POS_W-1:0]    first,
        input logic [STOP_W-1:0]   stop,
        input logic                lsb
    );
        lane_t             r;
        logic [CNT_W-1:0]  k;
        logic [CNT_W-1:0]  span;
        logic [STOP_W-1:0] idx;
        r.acc  = acc;
        r.hit  = 1'b0;
        r.last = 1'b0;
        span   = CNT_W'(SAMPLE_W) - CNT_W'(stop);
        k      = pos - CNT_W'(first);
        if ((pos >= CNT_W'(first)) && (k < span)) begin
            r.hit  = 1'b1;
            r.last = (k == span - 1'b1);
            if (k == '0) r.acc = '0;
            if (bit_order_e'(lsb) == ORDER_LSB)
                idx = STOP_W'(CNT_W'(stop) + k);
            else
                idx = STOP_W'(CNT_W'(SAMPLE_W - 1) - k);
            r.acc[idx] = bit_v;
        end
        return r;
    endfunction

    cap_st_t          cap_q, cap_d;
    logic             frm_start;
    logic [CNT_W-1:0] pos_cur;
    lane_t            lu, ru;

    always_comb begin
        cap_d      = cap_q;
        cap_d.vld  = 1'b0;
        cap_d.err  = 1'b0;
        frm_start  = 1'b0;
        pos_cur    = cap_q.pos;
        lu         = '0;
        ru         = '0;
        if (evt_i) begin
            if (frame_pol_e'(pol_i) == START_ON_RISE)
                frm_start = cap_q.seen && !cap_q.ws_prev && ws_i;
            else
                frm_start = cap_q.seen && cap_q.ws_prev && !ws_i;
            pos_cur = frm_start ? '0 : cap_q.pos;
            if (frm_start) begin
                cap_d.err   = cap_q.lbusy || cap_q.rbusy;
                cap_d.lbusy = 1'b0;
                cap_d.rbusy = 1'b0;
            end
            lu = lane_step(cap_q.lw, sd_i, pos_cur, lstart_i, stop_i, lsb_i);
            ru = lane_step(cap_q.rw, sd_i, pos_cur, rstart_i, stop_i, lsb_i);
            if (lu.hit) begin
                cap_d.lw    = lu.acc;
                cap_d.lbusy = !lu.last;
            end
            if (ru.hit) begin
                cap_d.rw    = ru.acc;
                cap_d.rbusy = !ru.last;
                if (ru.last) begin
                    cap_d.vld = 1'b1;
                    cap_d.lo  = cap_d.lw;
                    cap_d.ro  = ru.acc;
                end
            end
            cap_d.seen    = 1'b1;
            cap_d.ws_prev = ws_i;
            cap_d.pos     = (pos_cur == CNT_W'(POS_SAT)) ? pos_cur : pos_cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_q.pos <= CNT_W'(POS_SAT);
        end else begin
            cap_q <= cap_d;
        end
    end

    assign left_o  = cap_q.lo;
    assign right_o = cap_q.ro;
    assign valid_o = cap_q.vld;
    assign err_o   = cap_q.err;

endmodule

// File: rtl/audio_ser_rx.sv
`timescale 1ns/1ps
module audio_ser_rx #(
    parameter int SAMPLE_W    = 16,
    parameter int POS_W       = 6,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_master,
    input  logic [DIV_W-1:0]            cfg_sck_div,
    input  logic [POS_W-1:0]            cfg_ws_div,
    input  logic                        cfg_frame_pol,
    input  logic                        cfg_fall_edge,
    input  logic                        cfg_lsb_first,
    input  logic [$clog2(SAMPLE_W)-1:0] cfg_stop_pos,
    input  logic [POS_W-1:0]            cfg_left_start,
    input  logic [POS_W-1:0]            cfg_right_start,
    input  logic                        sck_in,
    input  logic                        ws_in,
    input  logic                        sd_in,
    output logic                        sck_out,
    output logic                        ws_out,
    output logic [SAMPLE_W-1:0]         left_out,
    output logic [SAMPLE_W-1:0]         right_out,
    output logic                        valid_out,
    output logic                        err_out
);

    logic [2:0] pins_s;
    logic       sck_s, ws_s, sd_s;
    logic       sck_prev_q;
    logic       s_rise, s_fall;
    logic       g_rise, g_fall;
    logic       samp_evt, samp_ws;

    audio_ser_rx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_in, ws_in, sd_in}),
        .q_o   (pins_s)
    );

    assign {sck_s, ws_s, sd_s} = pins_s;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    assign s_rise = sck_s && !sck_prev_q;
    assign s_fall = !sck_s && sck_prev_q;

    audio_ser_rx_clkgen #(
        .DIV_W (DIV_W),
        .POS_W (POS_W)
    ) clkgen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cfg_master),
        .div_i       (cfg_sck_div),
        .ws_div_i    (cfg_ws_div),
        .pol_i       (cfg_frame_pol),
        .fall_edge_i (cfg_fall_edge),
        .sck_o       (sck_out),
        .ws_o        (ws_out),
        .rise_o      (g_rise),
        .fall_o      (g_fall)
    );

    always_comb begin
        if (cfg_master) begin
            samp_evt = cfg_fall_edge ? g_fall : g_rise;
            samp_ws  = ws_out;
        end else begin
            samp_evt = cfg_fall_edge ? s_fall : s_rise;
            samp_ws  = ws_s;
        end
    end

    audio_ser_rx_capture #(
        .SAMPLE_W (SAMPLE_W),
        .POS_W    (POS_W)
    ) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (samp_evt),
        .ws_i     (samp_ws),
        .sd_i     (sd_s),
        .pol_i    (cfg_frame_pol),
        .lsb_i    (cfg_lsb_first),
        .stop_i   (cfg_stop_pos),
        .lstart_i (cfg_left_start),
        .rstart_i (cfg_right_start),
        .left_o   (left_out),
        .right_o  (right_out),
        .valid_o  (valid_out),
        .err_o    (err_out)
    );

endmodule

// File: rtl/audio_ser_rx_chk.sv
`timescale 1ns/1ps
module audio_ser_rx_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_master,
    input logic                        cfg_fall_edge,
    input logic [$clog2(SAMPLE_W)-1:0] cfg_stop_pos,
    input logic                        sck_out,
    input logic                        ws_out,
    input logic [SAMPLE_W-1:0]         left_out,
    input logic [SAMPLE_W-1:0]         right_out,
    input logic                        valid_out,
    input logic                        err_out
);

    logic [SAMPLE_W-1:0] low_mask;
    assign low_mask = SAMPLE_W'((32'd1 << cfg_stop_pos) - 32'd1);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out);

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> ($stable(left_out) && $stable(right_out)));

    // R5
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (((left_out & low_mask) == '0) && ((right_out & low_mask) == '0)));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |=> !err_out);

    // R13
    slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!sck_out && !ws_out));

    // R11
    ws_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(cfg_master) && (ws_out != $past(ws_out)))
            |-> ((sck_out != $past(sck_out)) && (sck_out == cfg_fall_edge)));

endmodule

bind audio_ser_rx audio_ser_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_master    (cfg_master),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_stop_pos  (cfg_stop_pos),
    .sck_out       (sck_out),
    .ws_out        (ws_out),
    .left_out      (left_out),
    .right_out     (right_out),
    .valid_out     (valid_out),
    .err_out       (err_out)
);

// File: tb/audio_ser_rx_tb_top.sv
`timescale 1ns/1ps
module audio_ser_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0;
    logic [7:0]  cfg_sck_div = 8'd7;
    logic [5:0]  cfg_ws_div = 6'd63;
    logic        cfg_frame_pol = 1'b0;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_stop_pos = 4'd0;
    logic [5:0]  cfg_left_start = 6'd0;
    logic [5:0]  cfg_right_start = 6'd32;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b1;
    logic        sd_in = 1'b0;
    logic        sck_out, ws_out, valid_out, err_out;
    logic [15:0] left_out, right_out;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          vcnt = 0;
    int          ecnt = 0;
    logic [15:0] capl = '0;
    logic [15:0] capr = '0;

    always #2.5 clk = ~clk;

    audio_ser_rx dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_master      (cfg_master),
        .cfg_sck_div     (cfg_sck_div),
        .cfg_ws_div      (cfg_ws_div),
        .cfg_frame_pol   (cfg_frame_pol),
        .cfg_fall_edge   (cfg_fall_edge),
        .cfg_lsb_first   (cfg_lsb_first),
        .cfg_stop_pos    (cfg_stop_pos),
        .cfg_left_start  (cfg_left_start),
        .cfg_right_start (cfg_right_start),
        .sck_in          (sck_in),
        .ws_in           (ws_in),
        .sd_in           (sd_in),
        .sck_out         (sck_out),
        .ws_out          (ws_out),
        .left_out        (left_out),
        .right_out       (right_out),
        .valid_out       (valid_out),
        .err_out         (err_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_out) begin
                vcnt++;
                capl = left_out;
                capr = right_out;
            end
            if (err_out) ecnt++;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected sample built from the requirement text
    function automatic logic [15:0] model(input logic [127:0] bits, input int st,
                                          input int stop, input bit lsb);
        logic [15:0] r = '0;
        for (int k = 0; k < 16 - stop; k++) begin
            int idx = lsb ? stop + k : 15 - k;
            r[idx] = bits[st + k];
        end
        return r;
    endfunction

    task automatic do_reset();
        rst_n  = 1'b0;
        sck_in = cfg_fall_edge;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic w, input logic d);
        sck_in = cfg_fall_edge;
        repeat (2) @(negedge clk);
        ws_in = w;
        sd_in = d;
        repeat (2) @(negedge clk);
        sck_in = ~cfg_fall_edge;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [127:0] bits, input int len);
        for (int i = 0; i < len; i++)
            send_bit((i < len / 2) ? cfg_frame_pol : ~cfg_frame_pol, bits[i]);
    endtask

    task automatic prime();
        send_bit(~cfg_frame_pol, 1'b0);
        send_bit(~cfg_frame_pol, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "left_out in reset", 32'(left_out), 32'h0);
        check("R1", "right_out in reset", 32'(right_out), 32'h0);
        check("R1", "valid_out in reset", 32'(valid_out), 32'h0);
        check("R1", "err_out in reset", 32'(err_out), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R13", "slave sck_out/ws_out", 32'({sck_out, ws_out}), 32'h0);
    endtask

    task automatic t_msb_example();
        logic [127:0] pat = 128'h0F1E_2D3C_4B5A_6978_A5C3_9617_E84D_B02F;
        int v0;
        cfg_master = 0; cfg_frame_pol = 0; cfg_fall_edge = 0; cfg_lsb_first = 0;
        cfg_stop_pos = 4; cfg_left_start = 0; cfg_right_start = 32;
        do_reset();
        v0 = vcnt;
        prime();
        send_frame(pat, 64);
        repeat (8) @(negedge clk);
        check("R6", "one valid per frame", 32'(vcnt - v0), 32'd1);
        check("R3", "MSB-first left, stop 4", 32'(capl), 32'(model(pat, 0, 4, 0)));
        check("R6", "MSB-first right from 32", 32'(capr), 32'(model(pat, 32, 4, 0)));
        check("R5", "low nibbles zero", 32'({capl[3:0], capr[3:0]}), 32'h0);
    endtask

    task automatic t_lsb_falling();
        logic [127:0] pat = 128'h1357_9BDF_2468_ACE0_C0FF_EE12_3456_789A;
        int v0;
        cfg_master = 0; cfg_frame_pol = 1; cfg_fall_edge = 1; cfg_lsb_first = 1;
        cfg_stop_pos = 2; cfg_left_start = 5; cfg_right_start = 40;
        do_reset();
        v0 = vcnt;
        prime();
        send_frame(pat, 64);
        repeat (8) @(negedge clk);
        check("R2", "rising-ws frame start gives one sample", 32'(vcnt - v0), 32'd1);
        check("R4", "LSB-first left from 5, stop 2", 32'(capl), 32'(model(pat, 5, 2, 1)));
        check("R7", "falling-edge sampled right", 32'(capr), 32'(model(pat, 40, 2, 1)));
    endtask

    task automatic t_overrun_err();
        logic [127:0] pa = 128'hFFFF_0000_AAAA_5555_3333_CCCC_F0F0_0F0F;
        logic [127:0] pb = 128'h0000_0000_0000_0000_8421_1248_7E81_C33C;
        int v0, e0;
        cfg_master = 0; cfg_frame_pol = 0; cfg_fall_edge = 0; cfg_lsb_first = 0;
        cfg_stop_pos = 0; cfg_left_start = 0; cfg_right_start = 32;
        do_reset();
        v0 = vcnt; e0 = ecnt;
        prime();
        send_frame(pa, 40);
        repeat (8) @(negedge clk);
        check("R8", "no valid for short frame", 32'(vcnt - v0), 32'd0);
        send_frame(pb, 64);
        repeat (8) @(negedge clk);
        check("R8", "one err pulse", 32'(ecnt - e0), 32'd1);
        check("R8", "only the full frame is valid", 32'(vcnt - v0), 32'd1);
        check("R8", "left from full frame", 32'(capl), 32'(model(pb, 0, 0, 0)));
        check("R8", "right from full frame", 32'(capr), 32'(model(pb, 32, 0, 0)));
    endtask

    task automatic t_long_frame();
        logic [127:0] pat = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;
        int v0;
        cfg_master = 0; cfg_frame_pol = 0; cfg_fall_edge = 0; cfg_lsb_first = 0;
        cfg_stop_pos = 0; cfg_left_start = 0; cfg_right_start = 20;
        do_reset();
        v0 = vcnt;
        prime();
        send_frame(pat, 100);
        repeat (8) @(negedge clk);
        check("R9", "single sample in 100-bit frame", 32'(vcnt - v0), 32'd1);
        check("R9", "left from first field", 32'(capl), 32'(model(pat, 0, 0, 0)));
        check("R9", "right from first field", 32'(capr), 32'(model(pat, 20, 0, 0)));
    endtask

    task automatic t_master();
        logic [127:0] pat = 128'h0000_0000_0000_0000_D1B5_4A32_6C0F_E893;
        logic psck = 1'b0, pws = 1'b0;
        int   last_rise = -1, rises_since_fall = 0, bitpos = 0;
        int   bad_ws = 0, ws_events = 0, v0;
        bit   per_done = 0, frm_done = 0, half_done = 0, fall_seen = 0;
        cfg_master = 1; cfg_sck_div = 7; cfg_ws_div = 63; cfg_frame_pol = 0;
        cfg_fall_edge = 0; cfg_lsb_first = 0; cfg_stop_pos = 4;
        cfg_left_start = 0; cfg_right_start = 32;
        do_reset();
        v0 = vcnt;
        for (int c = 0; c < 2600; c++) begin
            @(negedge clk);
            if (sck_out && !psck) begin
                if (last_rise >= 0 && !per_done) begin
                    check("R10", "sck_out period", 32'(c - last_rise), 32'd8);
                    per_done = 1;
                end
                last_rise = c;
                rises_since_fall++;
            end
            if (ws_out != pws) begin
                ws_events++;
                if (!((sck_out != psck) && (sck_out == 1'b0))) bad_ws++;
            end
            if (ws_out && !pws && fall_seen && !half_done) begin
                check("R10", "ws_out low half", 32'(rises_since_fall), 32'd32);
                half_done = 1;
            end
            if (!ws_out && pws) begin
                if (fall_seen && !frm_done) begin
                    check("R10", "frame length in bits", 32'(rises_since_fall), 32'd64);
                    frm_done = 1;
                end
                fall_seen = 1;
                rises_since_fall = 0;
            end
            if (!sck_out && psck) begin
                bitpos = (!ws_out && pws) ? 0 : bitpos + 1;
                sd_in  = pat[(bitpos > 63) ? 63 : bitpos];
            end
            psck = sck_out;
            pws  = ws_out;
        end
        check("R11", "ws_out moved only on falling sck_out", 32'(bad_ws), 32'd0);
        check("R11", "ws_out toggled", 32'(ws_events > 4), 32'd1);
        check("R12", "master produced samples", 32'(vcnt - v0 >= 2), 32'd1);
        check("R12", "master left bits 0..11", 32'(capl), 32'(model(pat, 0, 4, 0)));
        check("R12", "master right bits 32..43", 32'(capr), 32'(model(pat, 32, 4, 0)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_msb_example();
        t_lsb_falling();
        t_overrun_err();
        t_long_frame();
        t_master();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule